// File: doc/BRIEF.md
# Secondary Cache Index Writeback-Invalidate Sequencer

This block carries out one index-addressed flush of a single block in a two-way secondary cache. The block may hold copies in smaller primary instruction and data caches, and those copies are cleaned first. A requester gives a start pulse with a physical address and two virtual-index bits. The sequencer then reads the selected secondary tag entry. If that entry is valid, it probes every primary subset block contained in the secondary block and clears the primary copies that match. Primary data that is dirty and out of step with the secondary copy is pushed back into the secondary cache first.

After the primary subsets, the secondary tag entry is rewritten as one whole word in the invalid state, with a freshly generated check code. The set's most-recently-used pointer is turned to the other way. Last, the system side receives either a writeback of the block, when it was dirty, or a tag-invalidation notice, when it was clean. All tag arrays are plain synchronous RAMs outside the block: a read issued in one cycle returns its data in the next cycle.

Top module: `wbinvSeq`

## Requirements
- R1: A start pulse is accepted only while the block is idle. `busy` is high from the cycle after acceptance until the operation ends, and `done` is then high for exactly one cycle, during which `busy` is low. A start pulse while busy is ignored: it causes no second secondary tag read.
- R2: The set index is `pa[BLK_OFF+SET_BITS-1:BLK_OFF]` and the target way is `pa[0]`. The secondary tag is read exactly once per operation, at `stagAddr = {set, way}`.
- R3: If the secondary state read (bits [1:0] of the tag word) is 00 (Invalid), the operation finishes with no write to any array, no MRU update, no writeback and no system request.
- R4: Each primary instruction subset (`priAddr = {set, sub}`) whose tag equals the secondary tag and whose state bit is 1 is written with state 0 and parity 0. Any other instruction subset is left unwritten.
- R5: Each primary data subset whose tag equals the secondary tag and whose 2-bit state is nonzero is written with state 00, modifier 001, way bit 0 and parity 0. Any other data subset is left unwritten.
- R6: A matching data subset with state 11 and modifier 010 raises `l2WbEn`, carrying that subset's own tag and way bit, in the same cycle as its invalidating write. No other subset raises it.
- R7: A valid entry is rewritten as `{pa tag bits, va, 2'b00}` (tag in bits [WORD_W-1:4], virtual index in [3:2], state in [1:0]). Check bit k is the XOR of word bits 8k up to 8k+7, so each byte together with its check bit has even parity.
- R8: For a valid entry, the MRU bit of the set is written to the inverse of the target way. For an invalid entry, it is not written.
- R9: For original state 11, one system request with kind 0 (writeback) is made. For state 01 or 10, one request with kind 1 (tag invalidate) is made. Both carry the original secondary tag and the set. `sysValid` and `sysKind` hold steady while `sysReady` is low.
- R10: All instruction subsets are handled before any data subset. The tag rewrite and the MRU update come together after the last data subset, and the system request comes after them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for one operation |
| pa | input | PA_W | Physical address of the operation |
| va | input | 2 | Virtual index bits to store in the tag |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| stagRdEn | output | 1 | Secondary tag read strobe |
| stagWrEn | output | 1 | Secondary tag write strobe |
| stagAddr | output | SET_BITS+1 | Secondary tag address {set, way} |
| stagRdData | input | WORD_W | Secondary tag word, one cycle after read |
| stagWrData | output | WORD_W | Secondary tag word to write |
| stagWrEcc | output | ECC_W | Check bits for the written word |
| priAddr | output | SET_BITS+SUB_BITS | Primary subset address {set, sub} |
| iRdEn | output | 1 | Instruction tag read strobe |
| iRdTag | input | TAG_W | Instruction subset tag |
| iRdState | input | 1 | Instruction subset valid bit |
| iWrEn | output | 1 | Instruction state write strobe |
| iWrState | output | 1 | Instruction state value written |
| iWrPar | output | 1 | Instruction state parity written |
| dRdEn | output | 1 | Data tag read strobe |
| dRdTag | input | TAG_W | Data subset tag |
| dRdState | input | 2 | Data subset state |
| dRdMod | input | 3 | Data subset modifier field |
| dRdWay | input | 1 | Data subset secondary way bit |
| dWrEn | output | 1 | Data state write strobe |
| dWrState | output | 2 | Data state written |
| dWrMod | output | 3 | Modifier written |
| dWrWay | output | 1 | Way bit written |
| dWrPar | output | 1 | Data state parity written |
| l2WbEn | output | 1 | Push primary data into secondary |
| l2WbTag | output | TAG_W | Tag of the pushed block |
| l2WbWay | output | 1 | Secondary way of the pushed block |
| mruWrEn | output | 1 | MRU write strobe |
| mruSet | output | SET_BITS | Set whose MRU bit is written |
| mruWrVal | output | 1 | MRU value written |
| sysValid | output | 1 | System request valid |
| sysReady | input | 1 | System side accepts request |
| sysKind | output | 1 | 0 writeback, 1 tag invalidate |
| sysTag | output | TAG_W | Original secondary tag |
| sysSet | output | SET_BITS | Set of the flushed block |

## Verification
The hardest case to reach is a primary data subset that matches the secondary tag and is both dirty and inconsistent. It needs a valid secondary entry, a tag match and two particular field values all at once, and it has to sit beside neighbouring subsets in other states. The bench reaches it with a sweep over all four secondary states, both ways and sixteen patterns. Each subset's fields are taken from different bits of an arithmetic mix of the pattern, subset and set numbers, so every mixture of match, state and modifier comes up. System stalls of zero to two cycles and a start pulse during busy are mixed into the same sweep.

// File: rtl/wbinv_pkg.sv
package wbinv_pkg;
  localparam logic [1:0] ST_INVALID = 2'b00;
  localparam logic [1:0] ST_DIRTY   = 2'b11;
  localparam logic [2:0] MOD_NORMAL = 3'b001;
  localparam logic [2:0] MOD_INCONS = 3'b010;
  localparam logic       SYS_WRITEBACK = 1'b0;
  localparam logic       SYS_TAGINVAL  = 1'b1;

  typedef enum logic [3:0] {
    S_IDLE, S_SRD, S_SCHK, S_IRD, S_ICHK, S_DRD, S_DCHK, S_TWR, S_SYS, S_DONE
  } seqState_t;

  typedef struct packed {
    logic capReq;   // latch address and virtual index
    logic capTag;   // latch secondary tag and state
    logic subClr;   // restart subset counter
    logic subInc;   // next subset
    logic tagWr;    // secondary tag rewrite cycle
  } ctrlStrb_t;
endpackage

// File: rtl/wbinvCtrl.sv
module wbinvCtrl
  import wbinv_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      sValid,
  input  logic      iHit,
  input  logic      dHit,
  input  logic      dFlush,
  input  logic      lastSub,
  input  logic      sysReady,
  output ctrlStrb_t strb,
  output logic      busy,
  output logic      done,
  output logic      stagRdEn,
  output logic      stagWrEn,
  output logic      iRdEn,
  output logic      iWrEn,
  output logic      dRdEn,
  output logic      dWrEn,
  output logic      l2WbEn,
  output logic      mruWrEn,
  output logic      sysValid
);
  seqState_t curSt, nxtSt;

  always_ff @(posedge clk) begin
    if (!rstN) curSt <= S_IDLE;
    else       curSt <= nxtSt;
  end

  always_comb begin
    nxtSt    = curSt;
    strb     = '0;
    stagRdEn = 1'b0;
    stagWrEn = 1'b0;
    iRdEn    = 1'b0;
    iWrEn    = 1'b0;
    dRdEn    = 1'b0;
    dWrEn    = 1'b0;
    l2WbEn   = 1'b0;
    mruWrEn  = 1'b0;
    sysValid = 1'b0;
    unique case (curSt)
      S_IDLE: if (start) begin
        strb.capReq = 1'b1;
        nxtSt = S_SRD;
      end
      S_SRD: begin
        stagRdEn = 1'b1;
        nxtSt = S_SCHK;
      end
      S_SCHK: begin
        if (!sValid) nxtSt = S_DONE;
        else begin
          strb.capTag = 1'b1;
          strb.subClr = 1'b1;
          nxtSt = S_IRD;
        end
      end
      S_IRD: begin
        iRdEn = 1'b1;
        nxtSt = S_ICHK;
      end
      S_ICHK: begin
        iWrEn = iHit;
        if (lastSub) begin
          strb.subClr = 1'b1;
          nxtSt = S_DRD;
        end else begin
          strb.subInc = 1'b1;
          nxtSt = S_IRD;
        end
      end
      S_DRD: begin
        dRdEn = 1'b1;
        nxtSt = S_DCHK;
      end
      S_DCHK: begin
        dWrEn  = dHit;
        l2WbEn = dFlush;
        if (lastSub) nxtSt = S_TWR;
        else begin
          strb.subInc = 1'b1;
          nxtSt = S_DRD;
        end
      end
      S_TWR: begin
        stagWrEn   = 1'b1;
        mruWrEn    = 1'b1;
        strb.tagWr = 1'b1;
        nxtSt = S_SYS;
      end
      S_SYS: begin
        sysValid = 1'b1;
        if (sysReady) nxtSt = S_DONE;
      end
      S_DONE: nxtSt = S_IDLE;
      default: nxtSt = S_IDLE;
    endcase
  end

  assign busy = (curSt != S_IDLE) && (curSt != S_DONE);
  assign done = (curSt == S_DONE);

  p_done_after_busy_r1: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(busy));
  p_iwr_after_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    iWrEn |-> $past(iRdEn));
  p_dwr_after_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    dWrEn |-> $past(dRdEn));
  p_flush_with_inval_r6: assert property (@(posedge clk) disable iff (!rstN)
    l2WbEn |-> dWrEn);
endmodule

// File: rtl/wbinvDatapath.sv
module wbinvDatapath
  import wbinv_pkg::*;
#(
  parameter int PA_W     = 16,
  parameter int SET_BITS = 3,
  parameter int BLK_OFF  = 5,
  parameter int SUB_BITS = 1,
  localparam int TAG_W   = PA_W - SET_BITS - BLK_OFF,
  localparam int WORD_W  = TAG_W + 4,
  localparam int ECC_W   = (WORD_W + 7) / 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  ctrlStrb_t                    strb,
  input  logic [PA_W-1:0]              pa,
  input  logic [1:0]                   va,
  input  logic [WORD_W-1:0]            stagRdData,
  input  logic [TAG_W-1:0]             iRdTag,
  input  logic                         iRdState,
  input  logic [TAG_W-1:0]             dRdTag,
  input  logic [1:0]                   dRdState,
  input  logic [2:0]                   dRdMod,
  input  logic                         dRdWay,
  output logic [SET_BITS:0]            stagAddr,
  output logic [SET_BITS+SUB_BITS-1:0] priAddr,
  output logic [WORD_W-1:0]            stagWrData,
  output logic [ECC_W-1:0]             stagWrEcc,
  output logic                         sValid,
  output logic                         iHit,
  output logic                         dHit,
  output logic                         dFlush,
  output logic                         lastSub,
  output logic                         iWrState,
  output logic                         iWrPar,
  output logic [1:0]                   dWrState,
  output logic [2:0]                   dWrMod,
  output logic                         dWrWay,
  output logic                         dWrPar,
  output logic [TAG_W-1:0]             l2WbTag,
  output logic                         l2WbWay,
  output logic [SET_BITS-1:0]          mruSet,
  output logic                         mruWrVal,
  output logic [TAG_W-1:0]             sysTag,
  output logic [SET_BITS-1:0]          sysSet,
  output logic                         sysKind
);
  logic [TAG_W-1:0]    newTag, sTagR;
  logic [SET_BITS-1:0] setR;
  logic                wayR;
  logic [1:0]          vaR, sStR;
  logic [SUB_BITS-1:0] subR;
  logic                unusedBits;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      newTag <= '0; setR <= '0; wayR <= 1'b0; vaR <= '0;
      sTagR  <= '0; sStR <= ST_INVALID; subR <= '0;
    end else begin
      if (strb.capReq) begin
        newTag <= pa[PA_W-1 -: TAG_W];
        setR   <= pa[BLK_OFF +: SET_BITS];
        wayR   <= pa[0];
        vaR    <= va;
      end
      if (strb.capTag) begin
        sTagR <= stagRdData[WORD_W-1 -: TAG_W];
        sStR  <= stagRdData[1:0];
      end
      if (strb.subClr)      subR <= '0;
      else if (strb.subInc) subR <= subR + 1'b1;
    end
  end

  assign unusedBits = ^{pa[BLK_OFF-1:1], stagRdData[3:2]};

  assign stagAddr = {setR, wayR};
  assign priAddr  = {setR, subR};
  assign lastSub  = &subR;
  assign sValid   = stagRdData[1:0] != ST_INVALID;

  assign iHit   = (iRdTag == sTagR) && iRdState;
  assign dHit   = (dRdTag == sTagR) && (dRdState != ST_INVALID);
  assign dFlush = dHit && (dRdState == ST_DIRTY) && (dRdMod == MOD_INCONS);

  assign iWrState = 1'b0;
  assign iWrPar   = 1'b0;
  assign dWrState = ST_INVALID;
  assign dWrMod   = MOD_NORMAL;
  assign dWrWay   = 1'b0;
  assign dWrPar   = 1'b0;
  assign l2WbTag  = dRdTag;
  assign l2WbWay  = dRdWay;

  assign stagWrData = {newTag, vaR, ST_INVALID};

  for (genvar g = 0; g < ECC_W; g++) begin : gEcc
    localparam int HI = (g * 8 + 7 < WORD_W - 1) ? g * 8 + 7 : WORD_W - 1;
    assign stagWrEcc[g] = ^stagWrData[HI:g*8];
  end

  assign mruSet   = setR;
  assign mruWrVal = ~wayR;
  assign sysTag   = sTagR;
  assign sysSet   = setR;
  assign sysKind  = (sStR == ST_DIRTY) ? SYS_WRITEBACK : SYS_TAGINVAL;

  p_ecc_even_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.tagWr |-> (^{stagWrData, stagWrEcc}) == 1'b0);
endmodule

// File: rtl/wbinvSeq.sv
module wbinvSeq
  import wbinv_pkg::*;
#(
  parameter int PA_W     = 16,
  parameter int SET_BITS = 3,
  parameter int BLK_OFF  = 5,
  parameter int SUB_BITS = 1,
  localparam int TAG_W   = PA_W - SET_BITS - BLK_OFF,
  localparam int WORD_W  = TAG_W + 4,
  localparam int ECC_W   = (WORD_W + 7) / 8
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         start,
  input  logic [PA_W-1:0]              pa,
  input  logic [1:0]                   va,
  output logic                         busy,
  output logic                         done,
  output logic                         stagRdEn,
  output logic                         stagWrEn,
  output logic [SET_BITS:0]            stagAddr,
  input  logic [WORD_W-1:0]            stagRdData,
  output logic [WORD_W-1:0]            stagWrData,
  output logic [ECC_W-1:0]             stagWrEcc,
  output logic [SET_BITS+SUB_BITS-1:0] priAddr,
  output logic                         iRdEn,
  input  logic [TAG_W-1:0]             iRdTag,
  input  logic                         iRdState,
  output logic                         iWrEn,
  output logic                         iWrState,
  output logic                         iWrPar,
  output logic                         dRdEn,
  input  logic [TAG_W-1:0]             dRdTag,
  input  logic [1:0]                   dRdState,
  input  logic [2:0]                   dRdMod,
  input  logic                         dRdWay,
  output logic                         dWrEn,
  output logic [1:0]                   dWrState,
  output logic [2:0]                   dWrMod,
  output logic                         dWrWay,
  output logic                         dWrPar,
  output logic                         l2WbEn,
  output logic [TAG_W-1:0]             l2WbTag,
  output logic                         l2WbWay,
  output logic                         mruWrEn,
  output logic [SET_BITS-1:0]          mruSet,
  output logic                         mruWrVal,
  output logic                         sysValid,
  input  logic                         sysReady,
  output logic                         sysKind,
  output logic [TAG_W-1:0]             sysTag,
  output logic [SET_BITS-1:0]          sysSet
);
  ctrlStrb_t strb;
  logic sValid, iHit, dHit, dFlush, lastSub;

  wbinvCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .sValid(sValid), .iHit(iHit),
    .dHit(dHit), .dFlush(dFlush), .lastSub(lastSub), .sysReady(sysReady),
    .strb(strb), .busy(busy), .done(done), .stagRdEn(stagRdEn),
    .stagWrEn(stagWrEn), .iRdEn(iRdEn), .iWrEn(iWrEn), .dRdEn(dRdEn),
    .dWrEn(dWrEn), .l2WbEn(l2WbEn), .mruWrEn(mruWrEn), .sysValid(sysValid)
  );

  wbinvDatapath #(
    .PA_W(PA_W), .SET_BITS(SET_BITS), .BLK_OFF(BLK_OFF), .SUB_BITS(SUB_BITS)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .pa(pa), .va(va),
    .stagRdData(stagRdData), .iRdTag(iRdTag), .iRdState(iRdState),
    .dRdTag(dRdTag), .dRdState(dRdState), .dRdMod(dRdMod), .dRdWay(dRdWay),
    .stagAddr(stagAddr), .priAddr(priAddr), .stagWrData(stagWrData),
    .stagWrEcc(stagWrEcc), .sValid(sValid), .iHit(iHit), .dHit(dHit),
    .dFlush(dFlush), .lastSub(lastSub), .iWrState(iWrState), .iWrPar(iWrPar),
    .dWrState(dWrState), .dWrMod(dWrMod), .dWrWay(dWrWay), .dWrPar(dWrPar),
    .l2WbTag(l2WbTag), .l2WbWay(l2WbWay), .mruSet(mruSet), .mruWrVal(mruWrVal),
    .sysTag(sysTag), .sysSet(sysSet), .sysKind(sysKind)
  );

  p_sys_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (sysValid && !sysReady) |=> (sysValid && $stable(sysKind) && $stable(sysTag)));
  p_mru_with_tag_r8: assert property (@(posedge clk) disable iff (!rstN)
    mruWrEn |-> stagWrEn);
endmodule

// File: tb/test_wbinvSeq.sv
module test_wbinvSeq;
  localparam int CLK_PERIOD = 10;
  localparam int PA_W = 16, SET_BITS = 3, BLK_OFF = 5, SUB_BITS = 1;
  localparam int TAG_W = PA_W - SET_BITS - BLK_OFF;
  localparam int WORD_W = TAG_W + 4;
  localparam int ECC_W = (WORD_W + 7) / 8;
  localparam int NS = 1 << SET_BITS;
  localparam int SUBS = 1 << SUB_BITS;
  localparam int NP = NS * SUBS;

  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [PA_W-1:0] pa = '0;
  logic [1:0] va = '0;
  logic busy, done, stagRdEn, stagWrEn;
  logic [SET_BITS:0] stagAddr;
  logic [WORD_W-1:0] stagRdData, stagWrData;
  logic [ECC_W-1:0] stagWrEcc;
  logic [SET_BITS+SUB_BITS-1:0] priAddr;
  logic iRdEn, iWrEn, iWrState, iWrPar, iRdState;
  logic [TAG_W-1:0] iRdTag, dRdTag, l2WbTag, sysTag;
  logic dRdEn, dWrEn, dRdWay, dWrWay, dWrPar, l2WbEn, l2WbWay;
  logic [1:0] dRdState, dWrState;
  logic [2:0] dRdMod, dWrMod;
  logic mruWrEn, mruWrVal, sysValid, sysReady, sysKind;
  logic [SET_BITS-1:0] mruSet, sysSet;

  wbinvSeq #(.PA_W(PA_W), .SET_BITS(SET_BITS), .BLK_OFF(BLK_OFF), .SUB_BITS(SUB_BITS)) i_wbinvSeq (
    .clk(clk), .rstN(rstN), .start(start), .pa(pa), .va(va), .busy(busy), .done(done),
    .stagRdEn(stagRdEn), .stagWrEn(stagWrEn), .stagAddr(stagAddr), .stagRdData(stagRdData),
    .stagWrData(stagWrData), .stagWrEcc(stagWrEcc), .priAddr(priAddr),
    .iRdEn(iRdEn), .iRdTag(iRdTag), .iRdState(iRdState), .iWrEn(iWrEn),
    .iWrState(iWrState), .iWrPar(iWrPar), .dRdEn(dRdEn), .dRdTag(dRdTag),
    .dRdState(dRdState), .dRdMod(dRdMod), .dRdWay(dRdWay), .dWrEn(dWrEn),
    .dWrState(dWrState), .dWrMod(dWrMod), .dWrWay(dWrWay), .dWrPar(dWrPar),
    .l2WbEn(l2WbEn), .l2WbTag(l2WbTag), .l2WbWay(l2WbWay), .mruWrEn(mruWrEn),
    .mruSet(mruSet), .mruWrVal(mruWrVal), .sysValid(sysValid), .sysReady(sysReady),
    .sysKind(sysKind), .sysTag(sysTag), .sysSet(sysSet)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // array models and event monitor
  logic [WORD_W-1:0] sMem[2*NS];
  logic [ECC_W-1:0]  sEcc[2*NS];
  logic              mruM[NS];
  logic [TAG_W-1:0]  iTagM[NP], dTagM[NP];
  logic              iStM[NP], iParM[NP], dWayM[NP], dParM[NP];
  logic [1:0]        dStM[NP];
  logic [2:0]        dModM[NP];
  logic [TAG_W-1:0]  wbTagL[64];
  logic              wbWayL[64];
  logic [SET_BITS+SUB_BITS-1:0] wbAddrL[64];
  int rdCnt = 0, sWrCnt = 0, mruCnt = 0, iWrCnt = 0, dWrCnt = 0, wbCnt = 0;
  int sysCnt = 0, sysVCyc = 0, orderErr = 0, phase = 0, stallLeft = 0, stallSet = 0;
  logic [SET_BITS:0] rdAddrSeen;
  logic sysKindL;
  logic [TAG_W-1:0] sysTagL;
  logic [SET_BITS-1:0] sysSetL;

  assign sysReady = (stallLeft == 0);

  always @(posedge clk) begin
    int ph;
    if (stagRdEn) begin
      stagRdData <= sMem[stagAddr];
      rdCnt <= rdCnt + 1;
      rdAddrSeen <= stagAddr;
      phase <= 0;
    end
    if (stagWrEn) begin
      sMem[stagAddr] <= stagWrData;
      sEcc[stagAddr] <= stagWrEcc;
      sWrCnt <= sWrCnt + 1;
    end
    if (iRdEn) begin iRdTag <= iTagM[priAddr]; iRdState <= iStM[priAddr]; end
    if (iWrEn) begin iStM[priAddr] <= iWrState; iParM[priAddr] <= iWrPar; iWrCnt <= iWrCnt + 1; end
    if (dRdEn) begin
      dRdTag <= dTagM[priAddr]; dRdState <= dStM[priAddr];
      dRdMod <= dModM[priAddr]; dRdWay <= dWayM[priAddr];
    end
    if (dWrEn) begin
      dStM[priAddr] <= dWrState; dModM[priAddr] <= dWrMod;
      dWayM[priAddr] <= dWrWay; dParM[priAddr] <= dWrPar; dWrCnt <= dWrCnt + 1;
    end
    if (l2WbEn) begin
      wbTagL[wbCnt % 64] <= l2WbTag; wbWayL[wbCnt % 64] <= l2WbWay;
      wbAddrL[wbCnt % 64] <= priAddr; wbCnt <= wbCnt + 1;
    end
    if (mruWrEn) begin mruM[mruSet] <= mruWrVal; mruCnt <= mruCnt + 1; end
    if (sysValid) sysVCyc <= sysVCyc + 1;
    if (sysValid && sysReady) begin
      sysCnt <= sysCnt + 1; sysKindL <= sysKind; sysTagL <= sysTag; sysSetL <= sysSet;
    end
    if (start && !busy) stallLeft <= stallSet;
    else if (sysValid && stallLeft != 0) stallLeft <= stallLeft - 1;
    ph = 0;
    if (iWrEn) ph = 1;
    if (dWrEn || l2WbEn) ph = 2;
    if (stagWrEn || mruWrEn) ph = 3;
    if (sysValid && sysReady) ph = 4;
    if (ph != 0 && !stagRdEn) begin
      if (ph < phase) orderErr <= orderErr + 1;
      phase <= ph;
    end
  end

  int nChecks = 0, nFails = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic runOp(input int set, input int way, input logic [1:0] sSt,
                       input int pat, input int stall, input bit poke);
    logic [TAG_W-1:0] oldTag, newTag;
    logic [WORD_W-1:0] expWord;
    logic [ECC_W-1:0] expEcc;
    logic eISt[SUBS], eIPar[SUBS], eDWay[SUBS], eDPar[SUBS];
    logic [1:0] eDSt[SUBS];
    logic [2:0] eDMod[SUBS];
    logic [TAG_W-1:0] xTag[SUBS];
    logic xWay[SUBS];
    int xAddr[SUBS];
    int xN, bRd, bSWr, bMru, bIWr, bDWr, bWb, bSys, bVCyc, bOrd, w;
    logic mruOld, okI, okD, okWb, otherOk;
    logic [WORD_W-1:0] otherWord;
    bit timedOut;
    int s, a;

    oldTag = TAG_W'(8'h5A ^ (pat * 3));
    newTag = TAG_W'(8'h3C ^ (pat * 5 + set));
    w = set * 2 + way;
    sMem[w] = {oldTag, 2'b11, sSt};
    sEcc[w] = '1;
    otherWord = {oldTag ^ 8'h0F, 2'b01, 2'b11};
    sMem[w ^ 1] = otherWord;
    mruOld = pat[0];
    mruM[set] = mruOld;
    xN = 0;
    for (int j = 0; j < SUBS; j++) begin
      a = set * SUBS + j;
      s = (pat * 13 + j * 7 + set * 3 + int'(sSt)) & 63;
      iTagM[a] = s[0] ? oldTag : oldTag ^ 8'h10;
      iStM[a]  = s[1];
      iParM[a] = 1'b1;
      dTagM[a] = s[2] ? oldTag : oldTag ^ 8'h20;
      dStM[a]  = 2'(s >> 3);
      dModM[a] = s[5] ? 3'b010 : (s[1] ? 3'b001 : 3'b100);
      dWayM[a] = s[0] ^ s[3];
      dParM[a] = 1'b1;
      eISt[j] = iStM[a]; eIPar[j] = iParM[a];
      eDSt[j] = dStM[a]; eDMod[j] = dModM[a]; eDWay[j] = dWayM[a]; eDPar[j] = dParM[a];
      if (sSt != 2'b00) begin
        if (iTagM[a] == oldTag && iStM[a]) begin eISt[j] = 1'b0; eIPar[j] = 1'b0; end
        if (dTagM[a] == oldTag && dStM[a] != 2'b00) begin
          if (dStM[a] == 2'b11 && dModM[a] == 3'b010) begin
            xTag[xN] = dTagM[a]; xWay[xN] = dWayM[a]; xAddr[xN] = a; xN++;
          end
          eDSt[j] = 2'b00; eDMod[j] = 3'b001; eDWay[j] = 1'b0; eDPar[j] = 1'b0;
        end
      end
    end
    expWord = {newTag, va, 2'b00};
    for (int k = 0; k < ECC_W; k++) begin
      expEcc[k] = 1'b0;
      for (int b = k * 8; b < k * 8 + 8 && b < WORD_W; b++) expEcc[k] = expEcc[k] ^ expWord[b];
    end

    bRd = rdCnt; bSWr = sWrCnt; bMru = mruCnt; bIWr = iWrCnt; bDWr = dWrCnt;
    bWb = wbCnt; bSys = sysCnt; bVCyc = sysVCyc; bOrd = orderErr;

    @(negedge clk);
    stallSet = stall;
    pa = {newTag, 3'(set), 4'b1010, 1'(way)};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R1 busy after start", longint'(busy), 1);
    if (poke) begin
      pa = {newTag ^ 8'hFF, 3'(set + 1), 4'b0101, 1'(~way)};
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    timedOut = 1'b1;
    for (int c = 0; c < 500; c++) begin
      if (done === 1'b1) begin timedOut = 1'b0; break; end
      @(negedge clk);
    end
    if (timedOut) begin
      chk(1'b0, "R1 watchdog on done", 0, 1);
      finishRun();
    end
    chk(busy === 1'b0, "R1 busy low with done", longint'(busy), 0);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R1 done single cycle", longint'({done, busy}), 0);

    chk(rdCnt - bRd == 1 && rdAddrSeen == (SET_BITS + 1)'(w), "R2 one tag read at set/way",
        longint'(rdAddrSeen), longint'(w));

    okI = 1'b1; okD = 1'b1;
    for (int j = 0; j < SUBS; j++) begin
      a = set * SUBS + j;
      if (iStM[a] !== eISt[j] || iParM[a] !== eIPar[j]) okI = 1'b0;
      if (dStM[a] !== eDSt[j] || dModM[a] !== eDMod[j] || dWayM[a] !== eDWay[j] ||
          dParM[a] !== eDPar[j]) okD = 1'b0;
    end
    okWb = (wbCnt - bWb == xN);
    if (okWb)
      for (int k = 0; k < xN; k++)
        if (wbTagL[(bWb + k) % 64] !== xTag[k] || wbWayL[(bWb + k) % 64] !== xWay[k] ||
            int'(wbAddrL[(bWb + k) % 64]) != xAddr[k]) okWb = 1'b0;
    otherOk = (sMem[w ^ 1] === otherWord);

    if (sSt == 2'b00) begin
      chk(sWrCnt == bSWr && mruCnt == bMru && iWrCnt == bIWr && dWrCnt == bDWr &&
          wbCnt == bWb && sysCnt == bSys && sysVCyc == bVCyc,
          "R3 invalid entry no activity",
          longint'(sWrCnt - bSWr + mruCnt - bMru + iWrCnt - bIWr + dWrCnt - bDWr + sysVCyc - bVCyc), 0);
      chk(sMem[w] === {oldTag, 2'b11, 2'b00} && mruM[set] === mruOld && okI && okD,
          "R3 arrays unchanged", longint'(sMem[w]), longint'({oldTag, 4'b1100}));
    end else begin
      chk(okI, "R4 instruction subsets", longint'(iWrCnt - bIWr), 0);
      chk(okD, "R5 data subsets", longint'(dWrCnt - bDWr), 0);
      chk(okWb, "R6 dirty inconsistent push", longint'(wbCnt - bWb), longint'(xN));
      chk(sMem[w] === expWord && sEcc[w] === expEcc && sWrCnt - bSWr == 1 && otherOk,
          "R7 tag word and check bits", longint'({sEcc[w], sMem[w]}), longint'({expEcc, expWord}));
      chk(mruM[set] === ~1'(way) && mruCnt - bMru == 1, "R8 mru to other way",
          longint'(mruM[set]), longint'(~1'(way)));
      chk(sysCnt - bSys == 1 && sysKindL === (sSt == 2'b11 ? 1'b0 : 1'b1) &&
          sysTagL === oldTag && sysSetL === 3'(set), "R9 system request",
          longint'({sysKindL, sysTagL}), longint'({(sSt == 2'b11 ? 1'b0 : 1'b1), oldTag}));
      chk(sysVCyc - bVCyc == stall + 1, "R9 valid held during stall",
          longint'(sysVCyc - bVCyc), longint'(stall + 1));
      chk(orderErr == bOrd, "R10 subset then tag then system order",
          longint'(orderErr - bOrd), 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 2 * NS; i++) begin sMem[i] = '0; sEcc[i] = '0; end
    for (int i = 0; i < NS; i++) mruM[i] = 1'b0;
    for (int i = 0; i < NP; i++) begin
      iTagM[i] = '0; iStM[i] = 1'b0; iParM[i] = 1'b0;
      dTagM[i] = '0; dStM[i] = '0; dModM[i] = '0; dWayM[i] = 1'b0; dParM[i] = 1'b0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0 && sysValid === 1'b0, "R1 reset state idle",
        longint'({busy, done, sysValid}), 0);
    chk({stagRdEn, stagWrEn, iWrEn, dWrEn, l2WbEn, mruWrEn} === 6'b0, "R3 reset no strobes",
        longint'({stagRdEn, stagWrEn, iWrEn, dWrEn, l2WbEn, mruWrEn}), 0);
    for (int st = 0; st < 4; st++)
      for (int wy = 0; wy < 2; wy++)
        for (int p = 0; p < 16; p++) begin
          va = 2'(p + wy);
          runOp((p + st) % NS, wy, 2'(st), p, p % 3, p == 5);
        end
    finishRun();
  end

  initial begin
    #(CLK_PERIOD * 200000);
    chk(1'b0, "R1 global watchdog", 0, 1);
    finishRun();
  end
endmodule